// File: doc/BRIEF.md
# Multi-Gain Sample Selector

Each stored pixel sample arrives as three conversions of the same charge, taken at a high, a medium and a low gain setting, each a 14-bit ADC code. The selector keeps exactly one of them. It picks the most sensitive conversion that is not overloaded and drops the two least significant bits of that conversion. The result is a 12-bit value plus a 2-bit tag that names the gain it came from. This compresses the dynamic range so that a 12-bit readout path can carry the full signal span, and downstream logic can rescale each word using its tag.

Overload is judged against a programmable threshold. When every conversion is overloaded, the selector emits a clamped full-scale low-gain word and raises a sticky flag. Each input strobe produces exactly one result, one clock later.

Top module: `mgs_sample_select`

## Requirements
- R1: After reset, out_valid, out_value, out_gain and ovf_sticky are all 0.
- R2: When code_hi is below ovl_thresh, the result carries gain tag 0 and out_value equals code_hi[13:2].
- R3: When code_hi is saturated and code_mid is below ovl_thresh, the result carries gain tag 1 and out_value equals code_mid[13:2].
- R4: When code_hi and code_mid are saturated and code_lo is below ovl_thresh, the result carries gain tag 2 and out_value equals code_lo[13:2].
- R5: When all three codes are saturated, the result carries gain tag 2, out_value is 12'hFFF, and ovf_sticky becomes 1 in the same cycle as that result.
- R6: Once set, ovf_sticky stays 1 through later unsaturated samples and is cleared only by reset.
- R7: A code equal to ovl_thresh counts as saturated, and a code of ovl_thresh-1 does not.
- R8: The 12-bit value is formed by truncation, not rounding. For example, a selected code of 14'h0007 gives 12'h001.
- R9: out_valid is high in the cycle after each cycle in which in_valid is sampled high, and low otherwise. Back-to-back strobes give back-to-back results.
- R10: While in_valid is low, out_value and out_gain hold their last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovl_thresh | input | 14 | Overload threshold; a code at or above it is saturated |
| in_valid | input | 1 | Sample strobe for the three codes |
| code_hi | input | 14 | Conversion at high gain (tag 0) |
| code_mid | input | 14 | Conversion at medium gain (tag 1) |
| code_lo | input | 14 | Conversion at low gain (tag 2) |
| out_valid | output | 1 | Result strobe |
| out_value | output | 12 | Truncated selected code, or 12'hFFF when clamped |
| out_gain | output | 2 | Gain tag of the selected conversion |
| ovf_sticky | output | 1 | Set when a sample had all three gains saturated |

## Verification
Every result, and any update to the sticky flag, appears on the outputs one clock edge after the edge that samples the strobe. No output changes at any other time. The bench drives inputs on the falling edge, so the next rising edge captures them and the result is checked on the falling edge that follows. For back-to-back strobes, each falling edge both checks the previous sample and presents the next one. The hold and stickiness checks look at the outputs one falling edge after the strobe is removed or after a clean sample.

// File: rtl/mgs_pkg.sv
package mgs_pkg;

    typedef enum logic [1:0] {
        GAIN_HI  = 2'd0,
        GAIN_MID = 2'd1,
        GAIN_LO  = 2'd2
    } gain_e;

endpackage

// File: rtl/mgs_sat_detect.sv
module mgs_sat_detect #(
    parameter int ADC_W  = 14,
    parameter int N_GAIN = 3
) (
    input  logic [N_GAIN*ADC_W-1:0] codes_flat,
    input  logic [ADC_W-1:0]        thresh,
    output logic [N_GAIN-1:0]       sat
);

    // One comparator per gain lane
    for (genvar g = 0; g < N_GAIN; g++) begin : g_lane
        assign sat[g] = (codes_flat[g*ADC_W +: ADC_W] >= thresh);
    end

endmodule

// File: rtl/mgs_pick.sv
module mgs_pick #(
    parameter int OUT_W  = 12,
    parameter int N_GAIN = 3,
    localparam int IDX_W = (N_GAIN > 1) ? $clog2(N_GAIN) : 1
) (
    input  logic [N_GAIN-1:0]       sat,
    input  logic [N_GAIN*OUT_W-1:0] trunc_flat,
    output logic [IDX_W-1:0]        sel_idx,
    output logic [OUT_W-1:0]        sel_val,
    output logic                    all_sat
);

    always_comb begin
        all_sat = &sat;
        sel_idx = IDX_W'(N_GAIN - 1);
        // lower index = higher gain = higher priority
        for (int i = N_GAIN - 1; i >= 0; i--) begin
            if (!sat[i]) sel_idx = IDX_W'(i);
        end
        sel_val = '0;
        for (int i = 0; i < N_GAIN; i++) begin
            if (sel_idx == IDX_W'(i)) sel_val = trunc_flat[i*OUT_W +: OUT_W];
        end
        if (all_sat) sel_val = '1;
    end

endmodule

// File: rtl/mgs_sample_select.sv
module mgs_sample_select #(
    parameter int ADC_W = 14,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] ovl_thresh,
    input  logic             in_valid,
    input  logic [ADC_W-1:0] code_hi,
    input  logic [ADC_W-1:0] code_mid,
    input  logic [ADC_W-1:0] code_lo,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_value,
    output logic [1:0]       out_gain,
    output logic             ovf_sticky
);

    import mgs_pkg::*;

    localparam int N_GAIN = 3;
    localparam int DROP   = ADC_W - OUT_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] val;
        logic [1:0]       gain;
        logic             ovf;
    } state_t;

    state_t state_d, state_q;

    logic [N_GAIN*ADC_W-1:0] codes_flat;
    logic [N_GAIN*OUT_W-1:0] trunc_flat;
    logic [N_GAIN-1:0]       sat;
    logic [1:0]              pick_idx;
    logic [OUT_W-1:0]        pick_val;
    logic                    pick_all_sat;

    assign codes_flat = {code_lo, code_mid, code_hi};
    assign trunc_flat = {code_lo[ADC_W-1:DROP], code_mid[ADC_W-1:DROP], code_hi[ADC_W-1:DROP]};

    mgs_sat_detect #(
        .ADC_W (ADC_W),
        .N_GAIN(N_GAIN)
    ) u_sat (
        .codes_flat(codes_flat),
        .thresh    (ovl_thresh),
        .sat       (sat)
    );

    mgs_pick #(
        .OUT_W (OUT_W),
        .N_GAIN(N_GAIN)
    ) u_pick (
        .sat       (sat),
        .trunc_flat(trunc_flat),
        .sel_idx   (pick_idx),
        .sel_val   (pick_val),
        .all_sat   (pick_all_sat)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.val  = pick_val;
            state_d.gain = pick_idx;
            if (pick_all_sat) state_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.vld;
    assign out_value  = state_q.val;
    assign out_gain   = state_q.gain;
    assign ovf_sticky = state_q.ovf;

    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (!out_valid && !ovf_sticky)); // R1
    AST_HI_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_hi < ovl_thresh) |=>
        (out_gain == GAIN_HI && out_value == $past(code_hi[ADC_W-1:DROP]))); // R2
    AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_hi >= ovl_thresh && code_mid >= ovl_thresh && code_lo >= ovl_thresh) |=>
        (out_gain == GAIN_LO && &out_value && ovf_sticky)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky); // R6
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_value) && $stable(out_gain))); // R10

endmodule

// File: tb/sim_mgs_sample_select.sv
module sim_mgs_sample_select;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] ovl_thresh;
    logic        in_valid;
    logic [13:0] code_hi, code_mid, code_lo;
    logic        out_valid;
    logic [11:0] out_value;
    logic [1:0]  out_gain;
    logic        ovf_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgs_sample_select u0 (
        .clk(clk), .rst_n(rst_n), .ovl_thresh(ovl_thresh), .in_valid(in_valid),
        .code_hi(code_hi), .code_mid(code_mid), .code_lo(code_lo),
        .out_valid(out_valid), .out_value(out_value), .out_gain(out_gain),
        .ovf_sticky(ovf_sticky)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Independent model of the selection rule
    task automatic model(input logic [13:0] th, input logic [13:0] h, input logic [13:0] m,
                         input logic [13:0] l, output int val, output int gain, output bit ovf);
        ovf = 1'b0;
        if (h < th)      begin gain = 0; val = int'(h) / 4; end
        else if (m < th) begin gain = 1; val = int'(m) / 4; end
        else if (l < th) begin gain = 2; val = int'(l) / 4; end
        else             begin gain = 2; val = 4095; ovf = 1'b1; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Single sample: drive at a falling edge, check at the next falling edge
    task automatic one_sample(input string req, input logic [13:0] h, input logic [13:0] m,
                              input logic [13:0] l, input bit exp_ovf);
        int v, g; bit o;
        model(ovl_thresh, h, m, l, v, g, o);
        code_hi = h; code_mid = m; code_lo = l; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " value"}, int'(out_value), v);
        chk({req, " gain"},  int'(out_gain), g);
        chk({req, " ovf"},   int'(ovf_sticky), int'(exp_ovf));
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 value", int'(out_value), 0);
        chk("R1 gain",  int'(out_gain), 0);
        chk("R1 ovf",   int'(ovf_sticky), 0);
    endtask

    task automatic test_gains();
        ovl_thresh = 14'h3000;
        one_sample("R2", 14'h1234, 14'h0100, 14'h0010, 1'b0);
        one_sample("R3", 14'h3100, 14'h2ABC, 14'h0800, 1'b0);
        one_sample("R4", 14'h3FFF, 14'h3100, 14'h0ABD, 1'b0);
    endtask

    task automatic test_threshold_edge();
        ovl_thresh = 14'h3000;
        one_sample("R7 equal", 14'h3000, 14'h2FFF, 14'h0000, 1'b0);
        chk("R7 eq gain", int'(out_gain), 1);
        one_sample("R7 below", 14'h2FFF, 14'h3000, 14'h3000, 1'b0);
        chk("R7 below gain", int'(out_gain), 0);
    endtask

    task automatic test_truncation();
        ovl_thresh = 14'h3000;
        one_sample("R8 hi", 14'h0007, 14'h0, 14'h0, 1'b0);
        chk("R8 no round", int'(out_value), 1);
        one_sample("R8 lo", 14'h3FFF, 14'h3FFF, 14'h0003, 1'b0);
        chk("R8 low code", int'(out_value), 0);
    endtask

    task automatic test_hold();
        ovl_thresh = 14'h3000;
        one_sample("R10 setup", 14'h3FFF, 14'h3100, 14'h0ABD, 1'b0);
        code_hi = 14'h0004; code_mid = 14'h0004; code_lo = 14'h0004;
        @(negedge clk);
        chk("R9 idle valid", int'(out_valid), 0);
        chk("R10 hold value", int'(out_value), 14'h0ABD / 4);
        chk("R10 hold gain",  int'(out_gain), 2);
    endtask

    task automatic test_back_to_back();
        ovl_thresh = 14'h2000;
        code_hi = 14'h1FFC; code_mid = 14'h0; code_lo = 14'h0; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 b2b first valid", int'(out_valid), 1);
        chk("R9 b2b first value", int'(out_value), 14'h1FFC / 4);
        chk("R9 b2b first gain",  int'(out_gain), 0);
        code_hi = 14'h2000; code_mid = 14'h1008; code_lo = 14'h0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 b2b second valid", int'(out_valid), 1);
        chk("R9 b2b second value", int'(out_value), 14'h1008 / 4);
        chk("R9 b2b second gain",  int'(out_gain), 1);
        @(negedge clk);
        chk("R9 b2b end valid", int'(out_valid), 0);
    endtask

    task automatic test_overflow();
        ovl_thresh = 14'h3000;
        chk("R6 pre ovf", int'(ovf_sticky), 0);
        one_sample("R5", 14'h3000, 14'h3500, 14'h3FFF, 1'b1);
        one_sample("R6 after clean", 14'h0100, 14'h0, 14'h0, 1'b1);
        @(negedge clk);
        chk("R6 idle ovf", int'(ovf_sticky), 1);
        do_reset();
        chk("R6 cleared by reset", int'(ovf_sticky), 0);
        ovl_thresh = 14'h0000;
        one_sample("R5 zero thresh", 14'h0000, 14'h0000, 14'h0000, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; ovl_thresh = 14'h3000;
        code_hi = '0; code_mid = '0; code_lo = '0;
        test_reset();
        test_gains();
        test_threshold_edge();
        test_truncation();
        test_hold();
        test_back_to_back();
        test_overflow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule